// File: doc/BRIEF.md
# Four-Stage Floating-Point Adder/Subtractor

This block adds or subtracts two binary floating-point numbers through four registered segments. Each number has a sign, a signed exponent and a fractional magnitude mantissa. The first segment picks the larger exponent and measures the gap between the exponents. The second segment shifts the mantissa of the smaller operand right by that gap. The third segment combines the two magnitudes. The fourth segment normalizes the result, either by undoing a carry out or by removing leading zeros left by cancellation.

Every segment is followed by a register, so a fresh operand pair can be accepted on every clock. A valid bit travels alongside the data. Precision lost in alignment or in overflow correction is truncated, not rounded. IEEE special values, rounding modes and exception flags are not part of the block. The only special result is an exact zero.

Top module: `fpa_pipe4`

## Requirements
- R1: An operand's value is (-1)^sign × 0.m × 2^exp. The exponent is 8-bit two's complement, and the mantissa is a 16-bit magnitude with the binary point above its MSB. Input operands are normalized, meaning mantissa bit 15 is 1.
- R2: The larger exponent, compared as a signed value, becomes the working exponent. The other operand's mantissa is shifted right by the exponent difference, and the bits shifted out are dropped.
- R3: When the exponent difference is 16 or more, the smaller operand contributes nothing. The result then equals the larger operand.
- R4: With op_sub = 0 the block computes A + B. With op_sub = 1 it computes A − B, by inverting B's sign before the magnitudes are combined.
- R5: When the effective signs match, the magnitudes are added and the result takes that sign. A carry out of bit 15 shifts the sum right one place and adds 1 to the exponent. The bit shifted out is dropped.
- R6: When the effective signs differ, the smaller aligned magnitude is subtracted from the larger. The result takes the sign of the larger magnitude.
- R7: A nonzero result with leading zeros is shifted left by the leading-zero count, and that count is subtracted from the exponent. Every nonzero result leaves with mantissa bit 15 set.
- R8: An exactly zero magnitude produces sign 0, exponent 0 and mantissa 0.
- R9: A pair presented with in_valid high in cycle c gives out_valid high with its result in cycle c+4. A cycle with in_valid low gives out_valid low four cycles later. One pair is accepted every cycle.
- R10: A synchronous active-low reset clears out_valid and all result outputs to 0 at the next clock edge, and discards any work in flight.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operand pair present this cycle |
| op_sub | input | 1 | 0 = add, 1 = subtract B from A |
| a_sign | input | 1 | Sign of A (1 = negative) |
| a_exp | input | 8 | Two's-complement exponent of A |
| a_mant | input | 16 | Normalized magnitude mantissa of A |
| b_sign | input | 1 | Sign of B |
| b_exp | input | 8 | Two's-complement exponent of B |
| b_mant | input | 16 | Normalized magnitude mantissa of B |
| out_valid | output | 1 | Result present this cycle |
| res_sign | output | 1 | Result sign |
| res_exp | output | 8 | Result exponent |
| res_mant | output | 16 | Result mantissa, normalized or zero |

## Verification
The bench covers several corner cases, each chosen to expose a specific fault:
- A negative exponent against a positive one. An unsigned comparison would pick the wrong exponent.
- Exponent gaps of 15, 16 and 25. An alignment that wraps the shift count would add garbage to the larger operand instead of nothing.
- Cancellation down to a single set bit, and subtraction where B has the larger magnitude. A faulty leading-zero counter, or taking the sign from A alone, would leave a denormal mantissa or a wrong sign.
- Carry-out with a dropped low bit, and exact-zero results. These catch a missing exponent increment, rounding instead of truncation, and a zero that still carries a stale exponent or sign.
- Back-to-back streaming, a bubble, and a reset while data is in flight. Together these expose any stage that stalls, duplicates or leaks results.

// File: rtl/fpa_pkg.sv
// Shared definitions for the four-stage floating-point adder.
// Assumes the sign-magnitude format described in the brief.
package fpa_pkg;
    localparam int FPA_EXP_W = 8;
    localparam int FPA_MAN_W = 16;

    // Effective operation once B's sign has been merged with the op select.
    typedef enum logic {
        OP_ADD = 1'b0,
        OP_SUB = 1'b1
    } fpa_op_e;
endpackage

// File: rtl/fpa_cmp_stage.sv
// Segment one: compares signed exponents, keeps the larger one, computes the
// non-negative difference, and orders the operands so the larger-exponent
// one is "big". The subtract select is folded into B's sign here.
// Assumes: exponents are two's complement, EXP_W bits wide.
module fpa_cmp_stage
    import fpa_pkg::*;
#(
    parameter int EXP_W = FPA_EXP_W,
    parameter int MAN_W = FPA_MAN_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             v_i,
    input  logic             op_sub,
    input  logic             a_s,
    input  logic [EXP_W-1:0] a_e,
    input  logic [MAN_W-1:0] a_m,
    input  logic             b_s,
    input  logic [EXP_W-1:0] b_e,
    input  logic [MAN_W-1:0] b_m,
    output logic             v_o,
    output logic             big_s,
    output logic [MAN_W-1:0] big_m,
    output logic             sml_s,
    output logic [MAN_W-1:0] sml_m,
    output logic [EXP_W-1:0] exp_o,
    output logic [EXP_W:0]   diff_o
);
    fpa_op_e               op;
    logic                  b_eff_s;
    logic                  a_ge;
    logic signed [EXP_W:0] ea_x;
    logic signed [EXP_W:0] eb_x;
    logic        [EXP_W:0] diff_c;

    // Sign-extend the exponents, pick the larger and form the gap.
    always_comb begin
        op      = fpa_op_e'(op_sub);
        b_eff_s = (op == OP_SUB) ? ~b_s : b_s;
        ea_x    = {a_e[EXP_W-1], a_e};
        eb_x    = {b_e[EXP_W-1], b_e};
        a_ge    = (ea_x >= eb_x);
        diff_c  = a_ge ? $unsigned(ea_x - eb_x) : $unsigned(eb_x - ea_x);
    end

    // Stage register: ordered operands, working exponent and gap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_o    <= 1'b0;
            big_s  <= 1'b0;
            big_m  <= '0;
            sml_s  <= 1'b0;
            sml_m  <= '0;
            exp_o  <= '0;
            diff_o <= '0;
        end else begin
            v_o    <= v_i;
            big_s  <= a_ge ? a_s : b_eff_s;
            big_m  <= a_ge ? a_m : b_m;
            sml_s  <= a_ge ? b_eff_s : a_s;
            sml_m  <= a_ge ? b_m : a_m;
            exp_o  <= a_ge ? a_e : b_e;
            diff_o <= diff_c;
        end
    end

    // R2: the working exponent is never below either input exponent.
    p_exp_max_r2: assert property (@(posedge clk) disable iff (!rst_n)
        v_i |=> ($signed(exp_o) >= $signed($past(a_e)))
             && ($signed(exp_o) >= $signed($past(b_e))));
endmodule

// File: rtl/fpa_align_stage.sv
// Segment two: shifts the smaller-exponent mantissa right by the exponent
// gap. Bits shifted out are dropped. A gap of MAN_W or more gives zero.
// Assumes: the gap arrives as an unsigned EXP_W+1 bit value.
module fpa_align_stage #(
    parameter int EXP_W = 8,
    parameter int MAN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             v_i,
    input  logic             big_s_i,
    input  logic [MAN_W-1:0] big_m_i,
    input  logic             sml_s_i,
    input  logic [MAN_W-1:0] sml_m_i,
    input  logic [EXP_W-1:0] exp_i,
    input  logic [EXP_W:0]   diff_i,
    output logic             v_o,
    output logic             big_s_o,
    output logic [MAN_W-1:0] big_m_o,
    output logic             sml_s_o,
    output logic [MAN_W-1:0] sml_m_o,
    output logic [EXP_W-1:0] exp_o
);
    localparam int DW = EXP_W + 1;

    logic             far;
    logic [MAN_W-1:0] shifted;

    // Right shift with an explicit flush for out-of-range gaps.
    always_comb begin
        far     = (diff_i >= DW'(MAN_W));
        shifted = far ? '0 : (sml_m_i >> diff_i);
    end

    // Stage register: aligned operand pair.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_o     <= 1'b0;
            big_s_o <= 1'b0;
            big_m_o <= '0;
            sml_s_o <= 1'b0;
            sml_m_o <= '0;
            exp_o   <= '0;
        end else begin
            v_o     <= v_i;
            big_s_o <= big_s_i;
            big_m_o <= big_m_i;
            sml_s_o <= sml_s_i;
            sml_m_o <= shifted;
            exp_o   <= exp_i;
        end
    end

    // R3: a gap of at least the mantissa width leaves nothing of the small operand.
    p_far_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (v_i && (diff_i >= DW'(MAN_W))) |=> (sml_m_o == '0));
    // R2: alignment can only shrink the smaller mantissa.
    p_align_shrink_r2: assert property (@(posedge clk) disable iff (!rst_n)
        v_i |=> (sml_m_o <= $past(sml_m_i)));
endmodule

// File: rtl/fpa_addsub_stage.sv
// Segment three: sign-magnitude add or subtract of the aligned mantissas.
// Matching signs add; differing signs subtract the smaller magnitude from
// the larger, and the result takes the larger one's sign.
// Assumes: mantissas are already aligned to a common exponent.
module fpa_addsub_stage #(
    parameter int EXP_W = 8,
    parameter int MAN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             v_i,
    input  logic             big_s_i,
    input  logic [MAN_W-1:0] big_m_i,
    input  logic             sml_s_i,
    input  logic [MAN_W-1:0] sml_m_i,
    input  logic [EXP_W-1:0] exp_i,
    output logic             v_o,
    output logic             s_o,
    output logic [EXP_W-1:0] exp_o,
    output logic [MAN_W:0]   mag_o
);
    logic [MAN_W:0] mag_c;
    logic           s_c;
    logic           big_ge;

    // Choose add or ordered subtract and the result sign.
    always_comb begin
        big_ge = (big_m_i >= sml_m_i);
        if (big_s_i == sml_s_i) begin
            mag_c = {1'b0, big_m_i} + {1'b0, sml_m_i};
            s_c   = big_s_i;
        end else if (big_ge) begin
            mag_c = {1'b0, big_m_i} - {1'b0, sml_m_i};
            s_c   = big_s_i;
        end else begin
            mag_c = {1'b0, sml_m_i} - {1'b0, big_m_i};
            s_c   = sml_s_i;
        end
    end

    // Stage register: raw magnitude with its carry bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_o   <= 1'b0;
            s_o   <= 1'b0;
            exp_o <= '0;
            mag_o <= '0;
        end else begin
            v_o   <= v_i;
            s_o   <= s_c;
            exp_o <= exp_i;
            mag_o <= mag_c;
        end
    end

    // R5: a same-sign sum is never smaller than the larger-exponent operand.
    p_add_grow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (v_i && (big_s_i == sml_s_i)) |=> (mag_o >= {1'b0, $past(big_m_i)}));
    // R6: a difference never exceeds either input and never carries out.
    p_sub_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (v_i && (big_s_i != sml_s_i)) |=> (!mag_o[MAN_W])
            && (mag_o[MAN_W-1:0] <= (($past(big_m_i) >= $past(sml_m_i)) ?
                                     $past(big_m_i) : $past(sml_m_i))));
endmodule

// File: rtl/fpa_norm_stage.sv
// Segment four: normalizes the raw magnitude. A carry out is undone by a
// one-place right shift and an exponent increment. Leading zeros are
// removed by a left shift with a matching exponent decrement. An exact
// zero is forced to a clean zero.
// Assumes: exponent overflow and underflow wrap, as they are out of scope.
module fpa_norm_stage #(
    parameter int EXP_W = 8,
    parameter int MAN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             v_i,
    input  logic             s_i,
    input  logic [EXP_W-1:0] exp_i,
    input  logic [MAN_W:0]   mag_i,
    output logic             v_o,
    output logic             s_o,
    output logic [EXP_W-1:0] exp_o,
    output logic [MAN_W-1:0] man_o
);
    localparam int LZW = $clog2(MAN_W + 1);

    logic [LZW-1:0]   lz;
    logic             found;
    logic             n_s;
    logic [EXP_W-1:0] n_exp;
    logic [MAN_W-1:0] n_man;

    // Leading-zero count of the low MAN_W bits, scanning from the MSB.
    always_comb begin
        lz    = '0;
        found = 1'b0;
        for (int i = 0; i < MAN_W; i++) begin
            if (!found && mag_i[MAN_W-1-i]) begin
                lz    = LZW'(i);
                found = 1'b1;
            end
        end
    end

    // Pick among zero, carry-out and left-shift normalization.
    always_comb begin
        if (mag_i == '0) begin
            n_s   = 1'b0;
            n_exp = '0;
            n_man = '0;
        end else if (mag_i[MAN_W]) begin
            n_s   = s_i;
            n_exp = exp_i + EXP_W'(1);
            n_man = mag_i[MAN_W:1];
        end else begin
            n_s   = s_i;
            n_exp = exp_i - EXP_W'(lz);
            n_man = mag_i[MAN_W-1:0] << lz;
        end
    end

    // Output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_o   <= 1'b0;
            s_o   <= 1'b0;
            exp_o <= '0;
            man_o <= '0;
        end else begin
            v_o   <= v_i;
            s_o   <= n_s;
            exp_o <= n_exp;
            man_o <= n_man;
        end
    end

    // R7: any nonzero result leaves with its mantissa MSB set.
    p_norm_msb_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (v_o && (man_o != '0)) |-> man_o[MAN_W-1]);
    // R8: a zero magnitude becomes an all-zero result.
    p_zero_clean_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (v_i && (mag_i == '0)) |=> (man_o == '0) && (exp_o == '0) && !s_o);
endmodule

// File: rtl/fpa_pipe4.sv
// Four-segment floating-point add/subtract pipeline: compare, align,
// combine, normalize. It accepts one operand pair per cycle, and each
// result appears four cycles after its pair.
// Assumes: normalized inputs; truncation instead of rounding.
module fpa_pipe4
    import fpa_pkg::*;
#(
    parameter int EXP_W = FPA_EXP_W,
    parameter int MAN_W = FPA_MAN_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             op_sub,
    input  logic             a_sign,
    input  logic [EXP_W-1:0] a_exp,
    input  logic [MAN_W-1:0] a_mant,
    input  logic             b_sign,
    input  logic [EXP_W-1:0] b_exp,
    input  logic [MAN_W-1:0] b_mant,
    output logic             out_valid,
    output logic             res_sign,
    output logic [EXP_W-1:0] res_exp,
    output logic [MAN_W-1:0] res_mant
);
    logic             c_v, c_bs, c_ss;
    logic [MAN_W-1:0] c_bm, c_sm;
    logic [EXP_W-1:0] c_e;
    logic [EXP_W:0]   c_d;
    logic             l_v, l_bs, l_ss;
    logic [MAN_W-1:0] l_bm, l_sm;
    logic [EXP_W-1:0] l_e;
    logic             m_v, m_s;
    logic [EXP_W-1:0] m_e;
    logic [MAN_W:0]   m_mag;

    fpa_cmp_stage #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cmp (
        .clk(clk), .rst_n(rst_n), .v_i(in_valid), .op_sub(op_sub),
        .a_s(a_sign), .a_e(a_exp), .a_m(a_mant),
        .b_s(b_sign), .b_e(b_exp), .b_m(b_mant),
        .v_o(c_v), .big_s(c_bs), .big_m(c_bm), .sml_s(c_ss), .sml_m(c_sm),
        .exp_o(c_e), .diff_o(c_d));

    fpa_align_stage #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_align (
        .clk(clk), .rst_n(rst_n), .v_i(c_v),
        .big_s_i(c_bs), .big_m_i(c_bm), .sml_s_i(c_ss), .sml_m_i(c_sm),
        .exp_i(c_e), .diff_i(c_d),
        .v_o(l_v), .big_s_o(l_bs), .big_m_o(l_bm), .sml_s_o(l_ss),
        .sml_m_o(l_sm), .exp_o(l_e));

    fpa_addsub_stage #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_addsub (
        .clk(clk), .rst_n(rst_n), .v_i(l_v),
        .big_s_i(l_bs), .big_m_i(l_bm), .sml_s_i(l_ss), .sml_m_i(l_sm),
        .exp_i(l_e),
        .v_o(m_v), .s_o(m_s), .exp_o(m_e), .mag_o(m_mag));

    fpa_norm_stage #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_norm (
        .clk(clk), .rst_n(rst_n), .v_i(m_v), .s_i(m_s), .exp_i(m_e),
        .mag_i(m_mag),
        .v_o(out_valid), .s_o(res_sign), .exp_o(res_exp), .man_o(res_mant));

    // R9: a valid pair yields a valid result exactly four cycles later.
    p_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##4 out_valid);
    // R9: an idle input cycle yields an idle output cycle four cycles later.
    p_bubble_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> ##4 !out_valid);
    // R10: reset clears the output side at the next edge.
    p_reset_clear_r10: assert property (@(posedge clk)
        !rst_n |=> !out_valid && (res_mant == '0) && (res_exp == '0) && !res_sign);
endmodule

// File: tb/sim_fpa_pipe4.sv
// Bench for fpa_pipe4: a streamed vector table, then directed reset,
// latency and bubble checks.
module sim_fpa_pipe4;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid, op_sub, a_sign, b_sign;
    logic [7:0]  a_exp, b_exp;
    logic [15:0] a_mant, b_mant;
    logic        out_valid, res_sign;
    logic [7:0]  res_exp;
    logic [15:0] res_mant;

    int n_checks = 0;
    int n_errors = 0;

    always #2.5 clk = ~clk;

    fpa_pipe4 u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sub(op_sub),
        .a_sign(a_sign), .a_exp(a_exp), .a_mant(a_mant),
        .b_sign(b_sign), .b_exp(b_exp), .b_mant(b_mant),
        .out_valid(out_valid), .res_sign(res_sign), .res_exp(res_exp),
        .res_mant(res_mant));

    // {op, sa, ea, ma, sb, eb, mb, exp_sign, exp_exp, exp_mant}
    localparam int NV = 18;
    localparam logic [75:0] VEC [NV] = '{
        {1'b0, 1'b0, 8'h00, 16'h8000, 1'b0, 8'h00, 16'h8000, 1'b0, 8'h01, 16'h8000}, // R5 carry out
        {1'b0, 1'b0, 8'h03, 16'hC000, 1'b0, 8'h01, 16'h8000, 1'b0, 8'h03, 16'hE000}, // R2 align A big
        {1'b0, 1'b0, 8'h01, 16'h8000, 1'b0, 8'h03, 16'hC000, 1'b0, 8'h03, 16'hE000}, // R2 align B big
        {1'b0, 1'b0, 8'h00, 16'h8000, 1'b0, 8'hFC, 16'hFFFF, 1'b0, 8'h00, 16'h8FFF}, // R2 truncation
        {1'b0, 1'b0, 8'hFF, 16'h8000, 1'b0, 8'h01, 16'h8000, 1'b0, 8'h01, 16'hA000}, // R2 signed compare
        {1'b0, 1'b0, 8'h05, 16'h9234, 1'b0, 8'hEC, 16'hFFFF, 1'b0, 8'h05, 16'h9234}, // R3 gap 25
        {1'b0, 1'b0, 8'h0A, 16'hA000, 1'b0, 8'hFA, 16'hFFFF, 1'b0, 8'h0A, 16'hA000}, // R3 gap 16
        {1'b0, 1'b0, 8'h0A, 16'hA000, 1'b0, 8'hFB, 16'hFFFF, 1'b0, 8'h0A, 16'hA001}, // R3 gap 15
        {1'b1, 1'b0, 8'h02, 16'hC000, 1'b0, 8'h01, 16'h8000, 1'b0, 8'h02, 16'h8000}, // R4 subtract
        {1'b1, 1'b0, 8'h00, 16'h8000, 1'b1, 8'h00, 16'h8000, 1'b0, 8'h01, 16'h8000}, // R4 minus negative
        {1'b1, 1'b0, 8'h01, 16'h8000, 1'b0, 8'h01, 16'hC000, 1'b1, 8'h00, 16'h8000}, // R6 B larger
        {1'b0, 1'b1, 8'h00, 16'hC000, 1'b0, 8'h00, 16'h8000, 1'b1, 8'hFF, 16'h8000}, // R6 mixed signs
        {1'b0, 1'b1, 8'hFE, 16'hF000, 1'b1, 8'hFE, 16'hF000, 1'b1, 8'hFF, 16'hF000}, // R5 negative sum
        {1'b0, 1'b0, 8'h00, 16'hFFFF, 1'b0, 8'h00, 16'h8000, 1'b0, 8'h01, 16'hBFFF}, // R5 dropped bit
        {1'b1, 1'b0, 8'h00, 16'h8001, 1'b0, 8'h00, 16'h8000, 1'b0, 8'hF1, 16'h8000}, // R7 lz 15
        {1'b1, 1'b0, 8'h04, 16'hF0F0, 1'b0, 8'h04, 16'hF000, 1'b0, 8'hFC, 16'hF000}, // R7 lz 8
        {1'b1, 1'b0, 8'h03, 16'hA5A5, 1'b0, 8'h03, 16'hA5A5, 1'b0, 8'h00, 16'h0000}, // R8 sub zero
        {1'b0, 1'b1, 8'hFF, 16'hC000, 1'b0, 8'hFF, 16'hC000, 1'b0, 8'h00, 16'h0000}  // R8 add zero
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic [50:0] op);
        in_valid = v;
        {op_sub, a_sign, a_exp, a_mant, b_sign, b_exp, b_mant} = op;
    endtask

    initial begin
        #900000;
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        drive(1'b0, '0);
        repeat (3) @(negedge clk);
        // R10: reset state at the ports.
        check("R10 reset valid", 64'(out_valid), 64'd0);
        check("R10 reset result", 64'({res_sign, res_exp, res_mant}), 64'd0);
        rst_n = 1'b1;

        // R1..R9: stream the table back to back, one pair per cycle.
        for (int i = 0; i < NV + 4; i++) begin
            @(negedge clk);
            if (i >= 4) begin
                check($sformatf("R9 valid vec%0d", i - 4), 64'(out_valid), 64'd1);
                check($sformatf("R1-vec%0d result", i - 4),
                      64'({res_sign, res_exp, res_mant}), 64'(VEC[i-4][24:0]));
            end
            if (i < NV) drive(1'b1, VEC[i][75:25]);
            else        drive(1'b0, '0);
        end

        // R9: a single pair is not visible at cycle 3 and appears at cycle 4.
        @(negedge clk);
        drive(1'b1, VEC[0][75:25]);
        @(negedge clk);
        drive(1'b0, '0);
        @(negedge clk);
        @(negedge clk);
        check("R9 not early", 64'(out_valid), 64'd0);
        @(negedge clk);
        check("R9 on time", 64'(out_valid), 64'd1);
        check("R9 on time data", 64'({res_sign, res_exp, res_mant}), 64'(VEC[0][24:0]));
        @(negedge clk);
        check("R9 bubble", 64'(out_valid), 64'd0);

        // R10: reset with work in flight discards it.
        drive(1'b1, VEC[1][75:25]);
        @(negedge clk);
        drive(1'b1, VEC[2][75:25]);
        @(negedge clk);
        drive(1'b0, '0);
        rst_n = 1'b0;
        @(negedge clk);
        check("R10 flush valid", 64'(out_valid), 64'd0);
        check("R10 flush data", 64'({res_sign, res_exp, res_mant}), 64'd0);
        rst_n = 1'b1;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            check("R10 no leak", 64'(out_valid), 64'd0);
        end

        $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule